// File: doc/BRIEF.md
# Scatter-Gather Descriptor Controller

This block walks a linked list of 32-byte transfer descriptors kept in system memory. Software points the block at the first descriptor, sets the run bit, and the engine fetches each descriptor over a 32-bit master port. It checks that the hardware-owned flag is set, hands the source address, destination address, length and flag bits to a separate data mover, and waits for the mover to report the bytes moved and a status byte. It then writes the result back into the descriptor and follows the link to the next one. Payload movement is not part of this block.

A descriptor whose owned flag is clear ends the walk. The engine either halts and reports the chain as complete, or, in polling mode, waits a programmable number of clocks and fetches the same descriptor again. A small register set gives software the sticky status flags, the control word and the current descriptor pointer. A single interrupt line is built from the enabled event sources. A self-clearing control bit resets every register and abandons any bus access in progress.

Top module: `sg_desc_ctrl`

## Requirements
- R1: After reset, the status word (offset 0x00), the control word (offset 0x10) and the descriptor pointer (offset 0x20) read as zero, `irq` is low and no memory request is raised.
- R2: Descriptor words are fetched at pointer+0x00 (source), +0x08 (destination), +0x10 (link), +0x18 (length in bits 15:0) and +0x1C (flag byte in bits 31:24). Each owned descriptor issues exactly one single-cycle mover command carrying those values, with flag bits 2:0 on `mv_flags`.
- R3: After the mover finishes, the engine writes one word to pointer+0x1C: bytes moved in bits 15:0, mover status in bits 23:16 and the flag byte in bits 31:24. Flag bit 7 (owned) is cleared in that byte when control bit 17 is 0 and kept when control bit 17 is 1.
- R4: After each write-back the descriptor pointer register holds the link field of the finished descriptor.
- R5: When a fetched descriptor has flag bit 7 clear and polling (control bit 18) is off, no mover command is issued, status bit 3 (chain done) sets and status bit 4 (busy) clears.
- R6: When polling is on, an unowned descriptor is refetched after the delay in control bits 26:19, the chain is not reported complete, and the walk resumes once memory marks the descriptor owned.
- R7: Status bits 0 (error), 1 (end of packet, from flag bit 0), 2 (descriptor done) and 3 (chain done) stay set until software writes 1 to them.
- R8: `irq` is control bit 4 ANDed with a pending flag. The flag is set by error (enable bit 0), end of packet (bit 1), any descriptor (bit 2), chain end (bit 3) or the count event. It stays set until a control write with bit 31 set. With no enables set, `irq` stays low.
- R9: With control bit 7 set, a count event fires when the number of finished descriptors reaches the value in control bits 15:8. The counter then restarts from zero.
- R10: With control bit 6 set, a mover status with bit 0 set halts the engine after that descriptor's write-back, and no further descriptor is started.
- R11: A control write with bit 16 set returns all registers to zero, drops any memory request on the next cycle and issues no further memory writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Memory acknowledge, one cycle |
| mem_rdata | input | 32 | Memory read data, valid with `mem_ack` |
| mv_cmd_valid | output | 1 | Mover command pulse |
| mv_src | output | 32 | Mover source address |
| mv_dst | output | 32 | Mover destination address |
| mv_len | output | 16 | Mover byte count |
| mv_flags | output | 3 | End of packet, fixed source, fixed destination |
| mv_done | input | 1 | Mover completion pulse |
| mv_bytes | input | 16 | Bytes moved |
| mv_status | input | 8 | Mover status byte, bit 0 is error |
| irq | output | 1 | Interrupt request |

## Verification
A wrong engine state shows up within a handful of cycles at the memory port. A stale word index or pointer fetches from the wrong offset, and the bench sees it at the next mover command as a source, destination or length that does not match the descriptor. A lost owned-bit check appears as an extra command, and a bad write-back as a mismatched word in the scoreboard at the moment it is written. Register-side faults, such as sticky bits that fail to hold, a pending flag that clears itself, or a counter that is not restarted, only appear when software next reads the status or samples `irq`, so the bench reads them right after each chain ends.

// File: rtl/sgd_pkg.sv
package sgd_pkg;
  localparam int AW     = 32;
  localparam int DW     = 32;
  localparam int RA_W   = 6;
  localparam int CNT_W  = 8;
  localparam int PDLY_W = 8;
  localparam int NWORDS = 5;
  localparam int WI_W   = $clog2(NWORDS);
  localparam int NSTICKY = 4;

  localparam logic [RA_W-1:0] RA_STAT = 6'h00;
  localparam logic [RA_W-1:0] RA_CTRL = 6'h10;
  localparam logic [RA_W-1:0] RA_NEXT = 6'h20;

  // control word bit positions
  localparam int CB_GIE      = 4;
  localparam int CB_RUN      = 5;
  localparam int CB_HALT_ERR = 6;
  localparam int CB_IE_CNT   = 7;
  localparam int CB_CNT_LO   = 8;
  localparam int CB_SRST     = 16;
  localparam int CB_KEEP_OWN = 17;
  localparam int CB_POLL     = 18;
  localparam int CB_PDLY_LO  = 19;
  localparam int CB_IRQ_CLR  = 31;
  localparam logic [DW-1:0] CTRL_STORE_MASK = 32'h07FE_FFFF;

  // descriptor flag byte / mover status bits
  localparam int DF_EOP = 0;
  localparam int DF_OWN = 7;
  localparam int SF_ERR = 0;

  typedef enum logic [3:0] {
    E_IDLE, E_FETCH, E_CHECK, E_POLL, E_CMD, E_WAIT, E_WB, E_NEXT, E_HALT
  } eng_st_t;

  typedef struct packed {
    logic [AW-1:0] src;
    logic [AW-1:0] dst;
    logic [AW-1:0] link;
    logic [15:0]   len;
    logic [7:0]    flags;
  } desc_t;

  // byte offset of the idx-th fetched word inside a descriptor
  function automatic logic [7:0] word_off(input logic [WI_W-1:0] idx);
    case (idx)
      3'd0:    return 8'h00;
      3'd1:    return 8'h08;
      3'd2:    return 8'h10;
      3'd3:    return 8'h18;
      default: return 8'h1C;
    endcase
  endfunction

  // result word stored back at offset 0x1C
  function automatic logic [DW-1:0] wb_word(input logic [15:0] moved,
                                            input logic [7:0] st,
                                            input logic [7:0] flags,
                                            input logic keep_own);
    logic [7:0] f;
    f = keep_own ? flags : (flags & 8'h7F);
    return {f, st, moved};
  endfunction

  // count event: true when this descriptor brings the tally to the limit
  function automatic logic cnt_hit(input logic en, input logic [CNT_W-1:0] cnt,
                                   input logic [CNT_W-1:0] limit);
    logic [CNT_W-1:0] nxt;
    nxt = cnt + 1'b1;
    return en && (limit != '0) && (nxt == limit);
  endfunction

  // ev order: {chain, desc, eop, err}, matching enable bits 3..0
  function automatic logic irq_cause(input logic [NSTICKY-1:0] en,
                                     input logic [NSTICKY-1:0] ev,
                                     input logic hit);
    return (|(en & ev)) || hit;
  endfunction
endpackage

// File: rtl/sgd_poll_timer.sv
module sgd_poll_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         load,
  input  logic [W-1:0] dly,
  output logic         expired
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt <= '0;
    else if (clr)         cnt <= '0;
    else if (load)        cnt <= dly;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/sgd_engine.sv
module sgd_engine
  import sgd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sreset,
  input  logic              run,
  input  logic              poll_en,
  input  logic              halt_on_err,
  input  logic              keep_own,
  input  logic [PDLY_W-1:0] poll_dly,
  input  logic [AW-1:0]     head,
  output logic              mem_req,
  output logic              mem_we,
  output logic [AW-1:0]     mem_addr,
  output logic [DW-1:0]     mem_wdata,
  input  logic              mem_ack,
  input  logic [DW-1:0]     mem_rdata,
  output logic              mv_cmd_valid,
  output logic [AW-1:0]     mv_src,
  output logic [AW-1:0]     mv_dst,
  output logic [15:0]       mv_len,
  output logic [2:0]        mv_flags,
  input  logic              mv_done,
  input  logic [15:0]       mv_bytes,
  input  logic [7:0]        mv_status,
  output logic              ev_desc,
  output logic              ev_eop,
  output logic              ev_err,
  output logic              ev_chain,
  output logic [AW-1:0]     link_out,
  output logic              busy
);
  eng_st_t         st;
  logic [WI_W-1:0] widx;
  logic [AW-1:0]   cur;
  desc_t           d;
  logic [15:0]     moved;
  logic [7:0]      mst;
  logic            tmr_load, tmr_exp;
  logic            owned;
  logic            last_word;

  assign owned     = d.flags[DF_OWN];
  assign last_word = (widx == WI_W'(NWORDS-1));
  assign tmr_load  = (st == E_CHECK) && !owned && poll_en;

  sgd_poll_timer #(.W(PDLY_W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .clr(sreset), .load(tmr_load),
    .dly(poll_dly), .expired(tmr_exp)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= E_IDLE; widx <= '0; cur <= '0; d <= '0; moved <= '0; mst <= '0;
    end else if (sreset) begin
      st <= E_IDLE; widx <= '0;
    end else begin
      case (st)
        E_IDLE: if (run) begin cur <= head; widx <= '0; st <= E_FETCH; end
        E_FETCH: if (mem_ack) begin
          case (widx)
            3'd0:    d.src   <= mem_rdata;
            3'd1:    d.dst   <= mem_rdata;
            3'd2:    d.link  <= mem_rdata;
            3'd3:    d.len   <= mem_rdata[15:0];
            default: d.flags <= mem_rdata[31:24];
          endcase
          if (last_word) st <= E_CHECK;
          else           widx <= widx + 1'b1;
        end
        E_CHECK: begin
          if (owned)        st <= E_CMD;
          else if (poll_en) st <= E_POLL;
          else              st <= E_HALT;
        end
        E_POLL: if (tmr_exp) begin widx <= '0; st <= E_FETCH; end
        E_CMD:  st <= E_WAIT;
        E_WAIT: if (mv_done) begin moved <= mv_bytes; mst <= mv_status; st <= E_WB; end
        E_WB:   if (mem_ack) st <= E_NEXT;
        E_NEXT: begin
          cur  <= d.link;
          widx <= '0;
          st   <= (mst[SF_ERR] && halt_on_err) ? E_HALT : E_FETCH;
        end
        E_HALT: if (!run) st <= E_IDLE;
        default: st <= E_IDLE;
      endcase
    end
  end

  assign mem_req   = (st == E_FETCH) || (st == E_WB);
  assign mem_we    = (st == E_WB);
  assign mem_addr  = cur + AW'(word_off((st == E_WB) ? WI_W'(NWORDS-1) : widx));
  assign mem_wdata = wb_word(moved, mst, d.flags, keep_own);

  assign mv_cmd_valid = (st == E_CMD);
  assign mv_src       = d.src;
  assign mv_dst       = d.dst;
  assign mv_len       = d.len;
  assign mv_flags     = d.flags[2:0];

  assign ev_desc  = (st == E_NEXT);
  assign ev_eop   = (st == E_NEXT) && d.flags[DF_EOP];
  assign ev_err   = (st == E_NEXT) && mst[SF_ERR];
  assign ev_chain = (st == E_CHECK) && !owned && !poll_en;
  assign link_out = d.link;
  assign busy     = (st != E_IDLE) && (st != E_HALT);

  // R2
  mv_cmd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mv_cmd_valid |=> !mv_cmd_valid);

  // R5
  own_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == E_CHECK && !owned) |=> !mv_cmd_valid);

  // R11
  srst_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sreset |=> !mem_req);

  // R10
  halt_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_err && halt_on_err && !sreset) |=> !busy);
endmodule

// File: rtl/sgd_regs.sv
module sgd_regs
  import sgd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [RA_W-1:0]   reg_addr,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  input  logic              ev_desc,
  input  logic              ev_eop,
  input  logic              ev_err,
  input  logic              ev_chain,
  input  logic [AW-1:0]     link_in,
  input  logic              busy,
  output logic              sreset,
  output logic              run,
  output logic              poll_en,
  output logic              halt_on_err,
  output logic              keep_own,
  output logic [PDLY_W-1:0] poll_dly,
  output logic [AW-1:0]     head,
  output logic              irq
);
  logic [DW-1:0]      ctrl_q;
  logic [AW-1:0]      next_q;
  logic [NSTICKY-1:0] sticky;
  logic [NSTICKY-1:0] ev_vec;
  logic [CNT_W-1:0]   dcnt;
  logic               pend;
  logic               wr_ctrl, wr_stat, wr_next, irq_clr, hit, cause;

  assign wr_ctrl = reg_wr && (reg_addr == RA_CTRL);
  assign wr_stat = reg_wr && (reg_addr == RA_STAT);
  assign wr_next = reg_wr && (reg_addr == RA_NEXT);
  assign sreset  = wr_ctrl && reg_wdata[CB_SRST];
  assign irq_clr = wr_ctrl && reg_wdata[CB_IRQ_CLR];
  assign ev_vec  = {ev_chain, ev_desc, ev_eop, ev_err};
  assign hit     = ev_desc && cnt_hit(ctrl_q[CB_IE_CNT], dcnt, ctrl_q[CB_CNT_LO +: CNT_W]);
  assign cause   = irq_cause(ctrl_q[NSTICKY-1:0], ev_vec, hit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0; next_q <= '0; dcnt <= '0; pend <= 1'b0;
    end else if (sreset) begin
      ctrl_q <= '0; next_q <= '0; dcnt <= '0; pend <= 1'b0;
    end else begin
      if (wr_ctrl) ctrl_q <= reg_wdata & CTRL_STORE_MASK;
      if (ev_desc)      next_q <= link_in;
      else if (wr_next) next_q <= reg_wdata;
      if (ev_desc && ctrl_q[CB_IE_CNT]) dcnt <= hit ? '0 : dcnt + 1'b1;
      pend <= irq_clr ? cause : (pend || cause);
    end
  end

  for (genvar i = 0; i < NSTICKY; i++) begin : g_sticky
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      sticky[i] <= 1'b0;
      else if (sreset) sticky[i] <= 1'b0;
      else             sticky[i] <= (sticky[i] && !(wr_stat && reg_wdata[i])) || ev_vec[i];
    end
  end

  always_comb begin
    case (reg_addr)
      RA_STAT: reg_rdata = {{(DW-NSTICKY-1){1'b0}}, busy, sticky};
      RA_CTRL: reg_rdata = ctrl_q;
      RA_NEXT: reg_rdata = next_q;
      default: reg_rdata = '0;
    endcase
  end

  assign run         = ctrl_q[CB_RUN];
  assign poll_en     = ctrl_q[CB_POLL];
  assign halt_on_err = ctrl_q[CB_HALT_ERR];
  assign keep_own    = ctrl_q[CB_KEEP_OWN];
  assign poll_dly    = ctrl_q[CB_PDLY_LO +: PDLY_W];
  assign head        = next_q;
  assign irq         = ctrl_q[CB_GIE] && pend;

  // R4
  link_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_desc && !sreset) |=> (next_q == $past(link_in)));

  // R7
  sticky_chain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_chain && !sreset) |=> sticky[3]);

  // R8
  irq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_clr && !sreset && !(|ev_vec)) |=> !irq);
endmodule

// File: rtl/sg_desc_ctrl.sv
module sg_desc_ctrl
  import sgd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [RA_W-1:0]   reg_addr,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [AW-1:0]     mem_addr,
  output logic [DW-1:0]     mem_wdata,
  input  logic              mem_ack,
  input  logic [DW-1:0]     mem_rdata,
  output logic              mv_cmd_valid,
  output logic [AW-1:0]     mv_src,
  output logic [AW-1:0]     mv_dst,
  output logic [15:0]       mv_len,
  output logic [2:0]        mv_flags,
  input  logic              mv_done,
  input  logic [15:0]       mv_bytes,
  input  logic [7:0]        mv_status,
  output logic              irq
);
  logic              sreset, run, poll_en, halt_on_err, keep_own, busy;
  logic [PDLY_W-1:0] poll_dly;
  logic [AW-1:0]     head, link;
  logic              ev_desc, ev_eop, ev_err, ev_chain;

  sgd_regs u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .ev_desc(ev_desc), .ev_eop(ev_eop), .ev_err(ev_err), .ev_chain(ev_chain),
    .link_in(link), .busy(busy), .sreset(sreset), .run(run), .poll_en(poll_en),
    .halt_on_err(halt_on_err), .keep_own(keep_own), .poll_dly(poll_dly),
    .head(head), .irq(irq)
  );

  sgd_engine u_eng (
    .clk(clk), .rst_n(rst_n), .sreset(sreset), .run(run), .poll_en(poll_en),
    .halt_on_err(halt_on_err), .keep_own(keep_own), .poll_dly(poll_dly), .head(head),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .mv_cmd_valid(mv_cmd_valid), .mv_src(mv_src), .mv_dst(mv_dst), .mv_len(mv_len),
    .mv_flags(mv_flags), .mv_done(mv_done), .mv_bytes(mv_bytes), .mv_status(mv_status),
    .ev_desc(ev_desc), .ev_eop(ev_eop), .ev_err(ev_err), .ev_chain(ev_chain),
    .link_out(link), .busy(busy)
  );
endmodule

// File: tb/sim_sg_desc_ctrl.sv
`timescale 1ns/1ps
module sim_sg_desc_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [5:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic        mem_ack = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        mv_cmd_valid;
  logic [31:0] mv_src, mv_dst;
  logic [15:0] mv_len;
  logic [2:0]  mv_flags;
  logic        mv_done = 1'b0;
  logic [15:0] mv_bytes = '0;
  logic [7:0]  mv_status = '0;
  logic        irq;

  logic [31:0] mem [0:255];
  logic [63:0] wbq [$];
  logic [82:0] cmdq [$];
  logic [7:0]  mv_st_cfg = '0;
  int n_chk = 0, n_bad = 0, cmd_cnt = 0, wr_cnt = 0, poll_rd = 0;
  bit finished = 1'b0;

  localparam logic [5:0] A_STAT = 6'h00, A_CTRL = 6'h10, A_NEXT = 6'h20;

  always #4 clk = ~clk;

  sg_desc_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .mv_cmd_valid(mv_cmd_valid), .mv_src(mv_src), .mv_dst(mv_dst), .mv_len(mv_len),
    .mv_flags(mv_flags), .mv_done(mv_done), .mv_bytes(mv_bytes), .mv_status(mv_status),
    .irq(irq)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic reg_write(input logic [5:0] a, input logic [31:0] v);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = v;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [5:0] a, output logic [31:0] v);
    @(negedge clk); reg_addr = a; #1; v = reg_rdata;
  endtask

  task automatic put_desc(input logic [31:0] base, input logic [31:0] src,
                          input logic [31:0] dst, input logic [31:0] link,
                          input logic [15:0] len, input logic [7:0] flags);
    mem[base[9:2]]     = src;
    mem[base[9:2] + 2] = dst;
    mem[base[9:2] + 4] = link;
    mem[base[9:2] + 6] = {16'h0, len};
    mem[base[9:2] + 7] = {flags, 24'h0};
  endtask

  // driver side of the scoreboard: expected mover command and write-back
  task automatic expect_desc(input logic [31:0] base, input logic [31:0] src,
                             input logic [31:0] dst, input logic [15:0] len,
                             input logic [7:0] flags, input logic [7:0] st,
                             input bit keep);
    logic [7:0] f;
    f = keep ? flags : {1'b0, flags[6:0]};
    cmdq.push_back({src, dst, len, flags[2:0]});
    wbq.push_back({base + 32'h1C, f, st, len});
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    repeat (4) @(negedge clk);
    for (int i = 0; i < 5000; i++) begin
      reg_read(A_STAT, v);
      if (!v[4]) break;
    end
  endtask

  // memory responder and write-back monitor
  initial begin
    forever begin
      @(negedge clk);
      if (mem_ack) mem_ack = 1'b0;
      else if (mem_req) begin
        mem_ack = 1'b1;
        if (mem_we) begin
          wr_cnt++;
          mem[mem_addr[9:2]] = mem_wdata;
          if (wbq.size() == 0) chk(1'b0, "R3", "unexpected write addr", mem_addr, 32'h0);
          else begin
            logic [63:0] e;
            e = wbq.pop_front();
            chk(mem_addr == e[63:32], "R3", "write-back address", mem_addr, e[63:32]);
            chk(mem_wdata == e[31:0], "R3", "write-back word", mem_wdata, e[31:0]);
          end
        end else begin
          mem_rdata = mem[mem_addr[9:2]];
          if (mem_addr == 32'h31C) poll_rd++;
        end
      end
    end
  end

  // data mover stub and command monitor
  initial begin
    forever begin
      @(negedge clk);
      if (mv_cmd_valid) begin
        logic [15:0] l;
        cmd_cnt++;
        l = mv_len;
        if (cmdq.size() == 0) chk(1'b0, "R2", "unexpected mover command src", mv_src, 32'h0);
        else begin
          logic [82:0] e;
          e = cmdq.pop_front();
          chk(mv_src == e[82:51], "R2", "command source", mv_src, e[82:51]);
          chk(mv_dst == e[50:19], "R2", "command destination", mv_dst, e[50:19]);
          chk({mv_len, 13'h0, mv_flags} == {e[18:3], 13'h0, e[2:0]}, "R2",
              "command length/flags", {mv_len, 13'h0, mv_flags}, {e[18:3], 13'h0, e[2:0]});
        end
        repeat (3) @(negedge clk);
        mv_bytes = l; mv_status = mv_st_cfg; mv_done = 1'b1;
        @(negedge clk);
        mv_done = 1'b0;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL R11 watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int cc0, wc0;
    for (int i = 0; i < 256; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    reg_read(A_STAT, v); chk(v == 0, "R1", "status after reset", v, 0);
    reg_read(A_CTRL, v); chk(v == 0, "R1", "control after reset", v, 0);
    reg_read(A_NEXT, v); chk(v == 0, "R1", "pointer after reset", v, 0);
    chk(!irq && !mem_req, "R1", "irq/mem_req after reset", {irq, mem_req}, 0);

    // three owned descriptors, then an unowned one; chain-end interrupt
    put_desc(32'h100, 32'h1000, 32'h2000, 32'h120, 16'd64,   8'h80);
    put_desc(32'h120, 32'h1100, 32'h2100, 32'h140, 16'd17,   8'h83);
    put_desc(32'h140, 32'h1200, 32'h2200, 32'h160, 16'd1500, 8'h84);
    put_desc(32'h160, 32'h1300, 32'h2300, 32'h180, 16'd8,    8'h00);
    expect_desc(32'h100, 32'h1000, 32'h2000, 16'd64,   8'h80, 8'h00, 1'b0);
    expect_desc(32'h120, 32'h1100, 32'h2100, 16'd17,   8'h83, 8'h00, 1'b0);
    expect_desc(32'h140, 32'h1200, 32'h2200, 16'd1500, 8'h84, 8'h00, 1'b0);
    reg_write(A_NEXT, 32'h100);
    reg_write(A_CTRL, 32'h38);
    wait_idle();
    chk(wbq.size() == 0 && cmdq.size() == 0, "R3", "chain scoreboard drained",
        wbq.size() + cmdq.size(), 0);
    chk(cmd_cnt == 3, "R5", "no command for unowned descriptor", cmd_cnt, 3);
    reg_read(A_NEXT, v); chk(v == 32'h160, "R4", "pointer follows link", v, 32'h160);
    reg_read(A_STAT, v); chk(v == 32'h0E, "R5", "status chain/desc/eop, not busy", v, 32'h0E);
    chk(irq == 1'b1, "R8", "chain-end interrupt", irq, 1);
    reg_write(A_STAT, 32'h0F);
    reg_read(A_STAT, v); chk(v == 0, "R7", "status cleared by write-one", v, 0);
    chk(irq == 1'b1, "R8", "interrupt pending after status clear", irq, 1);
    reg_write(A_CTRL, 32'h8000_0000);
    chk(irq == 1'b0, "R8", "interrupt cleared by bit 31", irq, 0);
    reg_read(A_CTRL, v); chk(v == 0, "R8", "clear bit not stored", v, 0);

    // owned flag kept on write-back, no interrupt enables
    put_desc(32'h180, 32'h3000, 32'h4000, 32'h1A0, 16'd256, 8'h81);
    expect_desc(32'h180, 32'h3000, 32'h4000, 16'd256, 8'h81, 8'h00, 1'b1);
    reg_write(A_NEXT, 32'h180);
    reg_write(A_CTRL, 32'h0002_0020);
    wait_idle();
    chk(wbq.size() == 0, "R3", "keep-owned write-back seen", wbq.size(), 0);
    chk(mem[32'h19C >> 2][31:24] == 8'h81, "R3", "owned flag kept", mem[32'h19C >> 2][31:24], 8'h81);
    chk(irq == 1'b0, "R8", "no interrupt with enables off", irq, 0);
    reg_write(A_CTRL, 32'h0);
    reg_write(A_STAT, 32'h0F);

    // error with halt-on-error
    mv_st_cfg = 8'h01;
    put_desc(32'h1C0, 32'h5000, 32'h6000, 32'h1E0, 16'd32, 8'h80);
    put_desc(32'h1E0, 32'h5100, 32'h6100, 32'h200, 16'd32, 8'h80);
    expect_desc(32'h1C0, 32'h5000, 32'h6000, 16'd32, 8'h80, 8'h01, 1'b0);
    cc0 = cmd_cnt;
    reg_write(A_NEXT, 32'h1C0);
    reg_write(A_CTRL, 32'h71);
    wait_idle();
    chk(cmd_cnt == cc0 + 1, "R10", "halted after errored descriptor", cmd_cnt, cc0 + 1);
    reg_read(A_STAT, v); chk(v == 32'h05, "R10", "status error+desc only", v, 32'h05);
    reg_read(A_NEXT, v); chk(v == 32'h1E0, "R4", "pointer at next after error", v, 32'h1E0);
    chk(irq == 1'b1, "R8", "error interrupt", irq, 1);
    mv_st_cfg = 8'h00;
    reg_write(A_CTRL, 32'h8000_0000);
    reg_write(A_STAT, 32'h0F);

    // descriptor count interrupt, limit 2
    put_desc(32'h220, 32'h7000, 32'h8000, 32'h240, 16'd4, 8'h80);
    put_desc(32'h240, 32'h7100, 32'h8100, 32'h260, 16'd5, 8'h80);
    put_desc(32'h260, 32'h7200, 32'h8200, 32'h280, 16'd6, 8'h80);
    expect_desc(32'h220, 32'h7000, 32'h8000, 16'd4, 8'h80, 8'h00, 1'b0);
    expect_desc(32'h240, 32'h7100, 32'h8100, 16'd5, 8'h80, 8'h00, 1'b0);
    expect_desc(32'h260, 32'h7200, 32'h8200, 16'd6, 8'h80, 8'h00, 1'b0);
    reg_write(A_NEXT, 32'h220);
    reg_write(A_CTRL, 32'h2B0);
    wait_idle();
    chk(irq == 1'b1, "R9", "count interrupt after two descriptors", irq, 1);
    reg_write(A_CTRL, 32'h8000_0290);
    chk(irq == 1'b0, "R9", "count interrupt cleared", irq, 0);
    put_desc(32'h2A0, 32'h7300, 32'h8300, 32'h2C0, 16'd7, 8'h80);
    expect_desc(32'h2A0, 32'h7300, 32'h8300, 16'd7, 8'h80, 8'h00, 1'b0);
    reg_write(A_NEXT, 32'h2A0);
    reg_write(A_CTRL, 32'h2B0);
    wait_idle();
    chk(irq == 1'b1, "R9", "count restarted after firing", irq, 1);
    chk(wbq.size() == 0, "R9", "count chain scoreboard drained", wbq.size(), 0);
    reg_write(A_CTRL, 32'h8000_0000);
    reg_write(A_STAT, 32'h0F);

    // polling on an unowned descriptor, delay 40
    put_desc(32'h300, 32'h9000, 32'hA000, 32'h320, 16'd12, 8'h01);
    cc0 = cmd_cnt;
    poll_rd = 0;
    reg_write(A_NEXT, 32'h300);
    reg_write(A_CTRL, 32'h0144_0020);
    repeat (400) @(negedge clk);
    reg_read(A_STAT, v);
    chk(v == 32'h10, "R6", "still busy, chain not complete", v, 32'h10);
    chk(cmd_cnt == cc0, "R6", "no command while unowned", cmd_cnt, cc0);
    chk(poll_rd >= 3 && poll_rd <= 12, "R6", "refetch rate honours delay", poll_rd, 7);
    expect_desc(32'h300, 32'h9000, 32'hA000, 16'd12, 8'h81, 8'h00, 1'b0);
    mem[32'h31C >> 2] = mem[32'h31C >> 2] | 32'h8000_0000;
    for (int i = 0; i < 2000 && wbq.size() != 0; i++) @(negedge clk);
    chk(wbq.size() == 0, "R6", "walk resumed once owned", wbq.size(), 0);
    repeat (4) @(negedge clk);
    reg_read(A_NEXT, v); chk(v == 32'h320, "R4", "pointer after polled descriptor", v, 32'h320);

    // software reset while polling
    wc0 = wr_cnt;
    reg_write(A_CTRL, 32'h0001_0000);
    chk(!mem_req, "R11", "request dropped after soft reset", mem_req, 0);
    reg_read(A_STAT, v); chk(v == 0, "R11", "status zero after soft reset", v, 0);
    reg_read(A_CTRL, v); chk(v == 0, "R11", "control zero after soft reset", v, 0);
    reg_read(A_NEXT, v); chk(v == 0, "R11", "pointer zero after soft reset", v, 0);
    repeat (100) @(negedge clk);
    chk(wr_cnt == wc0, "R11", "no writes after soft reset", wr_cnt, wc0);
    chk(!mem_req && !irq, "R11", "engine quiet after soft reset", {mem_req, irq}, 0);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule